// File: doc/BRIEF.md
# Byte-Window Frame Exchange Register Block

This block is the host-facing register file of a small network controller. Whole Ethernet frames cross between software and the wire one byte per register access. To send, software sets a transmit length and then writes the frame a byte at a time into a transmit window. The frame leaves on a byte stream once the number of bytes written equals that length. To receive, a frame arriving on a byte stream is stored whole in a receive buffer. Software then learns its length from a count register and drains it by reading a receive window over and over.

The block decodes the access address, holds both count registers and both frame buffers, and drives the two byte streams. The busy flag and the interrupt-control register belong to a neighbouring interrupt block. This block reads the busy flag in, returns the neighbour's control word on reads of its slot, and tells the neighbour when a frame was sent or stored, using one-cycle done pulses.

Top module: `nic_byte_regs`

## Requirements
- R1: Only address bits [5:0] are decoded. Any address with the same low six bits reaches the same register, for both reads and writes.
- R2: Read data and `rd_valid` appear one cycle after a read request. The read map is:
  - 0x00 and 0x04: the two identifier words.
  - 0x08: `busy_i` in bit 0.
  - 0x0C: the receive count.
  - 0x10: the transmit count.
  - 0x14: `ctl_rdata`.
  - 0x1C: the receive window.
  - 0x18, 0x20 and every other offset read as 0.
  - `ctl_sel` is high in any cycle that holds a request to offset 0x14.
- R3: A write to 0x10 stores the written value when it is at most 1514. A larger value stores 0. Either write sets the transmit write index back to 0.
- R4: A write to 0x20 stores `req_wdata[7:0]` at the write index and advances the index. When the advanced index equals the transmit count:
  - the frame is queued for output;
  - the count and the index both return to 0;
  - `tx_done` is high for exactly one cycle.
- R5: A write to 0x20 has no effect while a frame is still being emitted, or when the write index already equals 1514.
- R6: The outgoing stream presents the frame bytes in the order they were written. `out_valid` and `out_data` hold while `out_ready` is low. `out_last` marks the final byte.
- R7: A read of 0x1C while the receive count is non-zero returns the byte at the read index, advances the index and lowers the count by one. When the count is 0, the read returns 0 and changes nothing.
- R8: `in_ready` is low while `busy_i` is high, while the receive count is 1514 or more, or in the cycle after a frame is committed. Once a frame's first byte is taken, `in_ready` stays high until its last byte.
- R9: On the byte marked `in_last`:
  - the receive count becomes the frame length, capped at 1514, with bytes beyond 1514 discarded;
  - the read index returns to 0;
  - `rx_done` is high for one cycle.
- R10: When a frame commits in the same cycle as a receive-window read, the commit sets the count and read index. The read still returns the byte that was current before the commit.
- R11: Writes to 0x00, 0x04, 0x08, 0x0C, 0x18 and 0x1C change nothing.
- R12: After reset both counts are 0, no frame is being emitted and both done pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host access request this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Access address; bits [5:0] are decoded |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the read request |
| rd_data | output | 32 | Read data |
| busy_i | input | 1 | Busy flag from the interrupt block |
| ctl_rdata | input | 32 | Interrupt-control word from the interrupt block |
| ctl_sel | output | 1 | Request addresses the interrupt-control slot |
| tx_done | output | 1 | One-cycle pulse when a transmit frame completes |
| rx_done | output | 1 | One-cycle pulse when a receive frame commits |
| in_valid | input | 1 | Incoming byte valid |
| in_data | input | 8 | Incoming byte |
| in_last | input | 1 | Incoming byte is the frame's last |
| in_ready | output | 1 | Block accepts an incoming byte |
| out_valid | output | 1 | Outgoing byte valid |
| out_data | output | 8 | Outgoing byte |
| out_last | output | 1 | Outgoing byte is the frame's last |
| out_ready | input | 1 | Sink accepts the outgoing byte |

## Verification
Two receive-side events can fall in the same cycle: a frame committing on its last incoming byte, and a host read popping the receive window. The bench provokes this by driving the final byte of a second frame in the same cycle as a window read, while part of the first frame has not yet been read. It then checks three things: the popped byte is the old byte at the old index, the count becomes the new frame's length, and the next pop returns the new frame's first byte. On the transmit side, a window write issued while a frame is waiting behind a low `out_ready` must leave the pending byte untouched.

// File: rtl/nic_byte_regs.sv
`timescale 1ns/1ps
module nic_byte_regs #(
  parameter int          FRAME_MAX = 1514,
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] ID_LO     = 32'h4E49_4342,
  parameter logic [31:0] ID_HI     = 32'h5954_4530
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic              busy_i,
  input  logic [31:0]       ctl_rdata,
  output logic              ctl_sel,
  output logic              tx_done,
  output logic              rx_done,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last,
  input  logic              out_ready
);
  localparam int CW = $clog2(FRAME_MAX + 1);
  localparam logic [CW-1:0] FMAX = CW'(FRAME_MAX);
  localparam logic [5:0] A_ID0 = 6'h00, A_ID1 = 6'h04, A_BUSY = 6'h08, A_RXCNT = 6'h0C,
                         A_TXCNT = 6'h10, A_CTL = 6'h14, A_RXWIN = 6'h1C, A_TXWIN = 6'h20;

  logic [5:0] a;
  logic       rd, wr;
  assign a  = req_addr[5:0];
  assign rd = req_valid & ~req_write;
  assign wr = req_valid & req_write;
  assign ctl_sel = req_valid & (a == A_CTL);

  // transmit side
  logic [7:0]    tx_mem [FRAME_MAX];
  logic [CW-1:0] tx_cnt, tx_widx, tx_len, tx_ridx;
  logic          tx_emit;
  logic          wr_tcnt, wr_tdat, tx_hit;
  logic [CW-1:0] cnt_in;

  assign wr_tcnt = wr & (a == A_TXCNT);
  assign wr_tdat = wr & (a == A_TXWIN) & ~tx_emit & (tx_widx < FMAX);
  assign tx_hit  = (tx_widx + 1'b1) == tx_cnt;
  assign cnt_in  = (req_wdata <= 32'(FRAME_MAX)) ? req_wdata[CW-1:0] : '0;

  assign out_valid = tx_emit;
  assign out_data  = tx_mem[tx_ridx];
  assign out_last  = tx_emit & (tx_ridx == tx_len - 1'b1);

  always_ff @(posedge clk)
    if (wr_tdat) tx_mem[tx_widx] <= req_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_cnt  <= '0;
      tx_widx <= '0;
      tx_len  <= '0;
      tx_ridx <= '0;
      tx_emit <= 1'b0;
      tx_done <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      if (tx_emit && out_ready) begin
        if (out_last) tx_emit <= 1'b0;
        else          tx_ridx <= tx_ridx + 1'b1;
      end
      if (wr_tcnt) begin
        tx_cnt  <= cnt_in;
        tx_widx <= '0;
      end
      if (wr_tdat) begin
        if (tx_hit) begin
          tx_emit <= 1'b1;
          tx_len  <= tx_cnt;
          tx_ridx <= '0;
          tx_cnt  <= '0;
          tx_widx <= '0;
          tx_done <= 1'b1;
        end else begin
          tx_widx <= tx_widx + 1'b1;
        end
      end
    end
  end

  // receive side
  logic [7:0]    rx_mem [FRAME_MAX];
  logic [CW-1:0] rx_cnt, rx_ridx, in_idx;
  logic          rx_act, take, room, pop, rx_full;

  assign rx_full  = rx_cnt >= FMAX;
  assign in_ready = rx_act | (~busy_i & ~rx_full & ~rx_done);
  assign take     = in_valid & in_ready;
  assign room     = in_idx < FMAX;
  assign pop      = rd & (a == A_RXWIN) & (rx_cnt != '0);

  always_ff @(posedge clk)
    if (take && room) rx_mem[in_idx] <= in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_cnt  <= '0;
      rx_ridx <= '0;
      in_idx  <= '0;
      rx_act  <= 1'b0;
      rx_done <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (pop) begin
        rx_cnt  <= rx_cnt - 1'b1;
        rx_ridx <= rx_ridx + 1'b1;
      end
      if (take) begin
        if (in_last) begin
          rx_cnt  <= room ? in_idx + 1'b1 : FMAX;
          rx_ridx <= '0;
          in_idx  <= '0;
          rx_act  <= 1'b0;
          rx_done <= 1'b1;
        end else begin
          rx_act <= 1'b1;
          if (room) in_idx <= in_idx + 1'b1;
        end
      end
    end
  end

  // read return
  logic [31:0] rmux;
  always_comb begin
    rmux = '0;
    unique case (a)
      A_ID0:   rmux = ID_LO;
      A_ID1:   rmux = ID_HI;
      A_BUSY:  rmux = {31'b0, busy_i};
      A_RXCNT: rmux = 32'(rx_cnt);
      A_TXCNT: rmux = 32'(tx_cnt);
      A_CTL:   rmux = ctl_rdata;
      A_RXWIN: rmux = pop ? {24'b0, rx_mem[rx_ridx]} : '0;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) rd_data <= rmux;
    end
  end
endmodule

module nic_byte_regs_chk #(
  parameter int FRAME_MAX = 1514,
  parameter int CW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_i,
  input logic          rx_act,
  input logic          in_ready,
  input logic          take,
  input logic          in_last,
  input logic          pop,
  input logic          tx_done,
  input logic          rx_done,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_data,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt
);
  AST_TXCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= CW'(FRAME_MAX)); // R3
  AST_TXDONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) tx_done |=> !tx_done); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6
  AST_POP_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !(take && in_last)) |=> (rx_cnt + 1'b1 == $past(rx_cnt))); // R7
  AST_READY_BUSY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !rx_act) |-> !in_ready); // R8
  AST_RXCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) rx_cnt <= CW'(FRAME_MAX)); // R9
  AST_COMMIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_last) |=> (rx_done && rx_cnt != '0)); // R10
endmodule

bind nic_byte_regs nic_byte_regs_chk #(.FRAME_MAX(FRAME_MAX), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .rx_act(rx_act), .in_ready(in_ready),
  .take(take), .in_last(in_last), .pop(pop), .tx_done(tx_done), .rx_done(rx_done),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/tb_nic_byte_regs.sv
`timescale 1ns/1ps
module tb_nic_byte_regs;
  localparam int MAXF = 1514;
  localparam logic [31:0] IDL = 32'h1234_5678, IDH = 32'h9ABC_DEF0, CTLV = 32'h0000_00A5;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [7:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic rd_valid, ctl_sel, tx_done, rx_done, in_ready, out_valid, out_last;
  logic [31:0] rd_data;
  logic busy = 0;
  logic in_valid = 0, in_last = 0, out_ready = 0;
  logic [7:0] in_data = 0, out_data;

  always #10 clk = ~clk;

  nic_byte_regs #(.FRAME_MAX(MAXF), .ADDR_W(8), .ID_LO(IDL), .ID_HI(IDH)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy_i(busy), .ctl_rdata(CTLV), .ctl_sel(ctl_sel), .tx_done(tx_done), .rx_done(rx_done),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready));

  int checks = 0, errors = 0;
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_txcnt = 0, m_twidx = 0, m_rxcnt = 0, m_rridx = 0, m_inidx = 0;
  bit m_ract = 0, m_txdone = 0, m_rxdone = 0, m_rvalid = 0, m_rdwin = 0;
  logic [31:0] m_rdata = 0;
  logic [7:0] m_tbuf [MAXF];
  logic [7:0] m_rbuf [MAXF];
  logic [7:0] m_txq [$];

  function automatic bit exp_ready();
    return m_ract || (!busy && m_rxcnt < MAXF && !m_rxdone);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_txcnt = 0; m_twidx = 0; m_rxcnt = 0; m_rridx = 0; m_inidx = 0;
      m_ract = 0; m_txdone = 0; m_rxdone = 0; m_rvalid = 0; m_txq.delete();
    end else begin
      automatic bit rdy = exp_ready();
      automatic bit emit = m_txq.size() > 0;
      automatic int a = int'(req_addr[5:0]);
      m_rvalid = req_valid && !req_write;
      m_rdwin = (a == 28);
      if (m_rvalid) begin
        m_rdata = 0;
        case (a)
          0: m_rdata = IDL;
          4: m_rdata = IDH;
          8: m_rdata = {31'b0, busy};
          12: m_rdata = m_rxcnt;
          16: m_rdata = m_txcnt;
          20: m_rdata = CTLV;
          28: if (m_rxcnt > 0) begin
                m_rdata = {24'b0, m_rbuf[m_rridx]};
                m_rxcnt--; m_rridx++;
              end
          default: m_rdata = 0;
        endcase
      end
      if (emit && out_ready) void'(m_txq.pop_front());
      m_txdone = 0;
      if (req_valid && req_write && a == 16) begin
        m_txcnt = (req_wdata <= MAXF) ? int'(req_wdata) : 0;
        m_twidx = 0;
      end
      if (req_valid && req_write && a == 32 && !emit && m_twidx < MAXF) begin
        m_tbuf[m_twidx] = req_wdata[7:0];
        m_twidx++;
        if (m_twidx == m_txcnt) begin
          for (int k = 0; k < m_txcnt; k++) m_txq.push_back(m_tbuf[k]);
          m_txcnt = 0; m_twidx = 0; m_txdone = 1;
        end
      end
      m_rxdone = 0;
      if (in_valid && rdy) begin
        if (m_inidx < MAXF) m_rbuf[m_inidx] = in_data;
        if (in_last) begin
          m_rxcnt = (m_inidx < MAXF) ? m_inidx + 1 : MAXF;
          m_rridx = 0; m_inidx = 0; m_ract = 0; m_rxdone = 1;
        end else begin
          m_ract = 1;
          if (m_inidx < MAXF) m_inidx++;
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always begin
    @(negedge clk); #2;
    if (rst_n) begin
      chk("R8 in_ready", in_ready, exp_ready());
      chk("R6 out_valid", out_valid, m_txq.size() > 0);
      if (m_txq.size() > 0) begin
        chk("R6 out_data", out_data, m_txq[0]);
        chk("R6 out_last", out_last, m_txq.size() == 1);
      end
      chk("R4 tx_done", tx_done, m_txdone);
      chk("R9 rx_done", rx_done, m_rxdone);
      chk("R2 ctl_sel", ctl_sel, req_valid && req_addr[5:0] == 6'h14);
      chk("R2 rd_valid", rd_valid, m_rvalid);
      if (m_rvalid) chk(m_rdwin ? "R7 rd_data" : "R2 rd_data", rd_data, m_rdata);
    end
  end

  task automatic wr(logic [7:0] ad, logic [31:0] d);
    @(negedge clk); req_valid = 1; req_write = 1; req_addr = ad; req_wdata = d;
    @(negedge clk); req_valid = 0; req_write = 0;
  endtask

  task automatic rdchk(logic [7:0] ad, logic [31:0] exp, string tag);
    @(negedge clk); req_valid = 1; req_write = 0; req_addr = ad;
    @(negedge clk); req_valid = 0;
    #3 chk(tag, rd_data, exp);
  endtask

  task automatic send_frame(int len, logic [7:0] base);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = base + 8'(i); in_last = (i == len - 1);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk); in_valid = 0; in_last = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20ns * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #3;
    // R12 reset state
    chk("R12 out_valid", out_valid, 0);
    chk("R12 done pulses", {tx_done, rx_done}, 0);
    rdchk(8'h0C, 0, "R12 rx count");
    rdchk(8'h10, 0, "R12 tx count");
    // R2 read map
    rdchk(8'h00, IDL, "R2 id low");
    rdchk(8'h04, IDH, "R2 id high");
    rdchk(8'h14, CTLV, "R2 ctl word");
    rdchk(8'h18, 0, "R2 info zero");
    rdchk(8'h20, 0, "R2 tx window zero");
    rdchk(8'h3C, 0, "R2 unmapped zero");
    busy = 1;
    rdchk(8'h08, 1, "R2 busy bit");
    busy = 0;
    // R1 aliasing
    rdchk(8'hC0, IDL, "R1 alias read");
    wr(8'h50, 9);
    rdchk(8'h10, 9, "R1 alias write");
    // R3 count limits
    wr(8'h10, 2000);
    rdchk(8'h10, 0, "R3 oversize count");
    wr(8'h10, MAXF);
    rdchk(8'h10, MAXF, "R3 max count");
    // R4/R5/R6 transmit
    out_ready = 0;
    wr(8'h10, 4);
    for (int i = 0; i < 4; i++) wr(8'h20, 32'hA0 + i);
    rdchk(8'h10, 0, "R4 count cleared");
    wr(8'h20, 32'hFF);
    #3 chk("R5 pending byte kept", out_data, 8'hA0);
    for (int i = 0; i < 12; i++) begin @(negedge clk); out_ready = i[0]; end
    @(negedge clk); out_ready = 1;
    repeat (4) @(negedge clk);
    chk("R6 frame drained", out_valid, 0);
    wr(8'h10, 0);
    for (int i = 0; i < MAXF + 2; i++) wr(8'h20, i);
    #3 chk("R5 capacity no emission", out_valid, 0);
    wr(8'h10, 2);
    wr(8'h20, 32'h55);
    wr(8'h20, 32'h66);
    repeat (4) @(negedge clk);
    // R11 read-only registers
    wr(8'h0C, 7); wr(8'h00, 1); wr(8'h08, 1); wr(8'h1C, 3); wr(8'h18, 5);
    rdchk(8'h0C, 0, "R11 rx count untouched");
    rdchk(8'h1C, 0, "R11 window untouched");
    // R9/R7 receive
    send_frame(6, 8'h10);
    busy = 1;
    rdchk(8'h0C, 6, "R9 frame length");
    rdchk(8'h1C, 8'h10, "R7 first byte");
    rdchk(8'h1C, 8'h11, "R7 second byte");
    rdchk(8'h1C, 8'h12, "R7 third byte");
    rdchk(8'h0C, 3, "R7 count decremented");
    #3 chk("R8 busy blocks", in_ready, 0);
    busy = 0;
    // R10 commit beside a pop
    in_valid = 1; in_data = 8'h40; in_last = 0;
    @(negedge clk); in_data = 8'h41;
    @(negedge clk); in_data = 8'h42; in_last = 1;
    req_valid = 1; req_write = 0; req_addr = 8'h1C;
    @(negedge clk); in_valid = 0; in_last = 0; req_valid = 0;
    #3 chk("R10 pop returns old byte", rd_data, 8'h13);
    rdchk(8'h0C, 3, "R10 count from commit");
    rdchk(8'h1C, 8'h40, "R10 index reset");
    rdchk(8'h1C, 8'h41, "R7 pop");
    rdchk(8'h1C, 8'h42, "R7 pop last");
    rdchk(8'h1C, 0, "R7 empty read zero");
    rdchk(8'h0C, 0, "R7 empty count");
    // R9 oversize frame, R8 full gate
    send_frame(1600, 8'h00);
    rdchk(8'h0C, MAXF, "R9 capped length");
    #3 chk("R8 full blocks", in_ready, 0);
    rdchk(8'h1C, 8'h00, "R9 read index cleared");
    #3 chk("R8 ready after pop", in_ready, 1);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule